// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block takes one source clock and produces a group of copies of it that can be halted without glitches. A single active-low stop request, arriving with no timing relation to the clock, is first brought into the clock domain through a flop chain. A small run controller then decides when the stoppable copies may switch. Each copy has its own enable bit, driven from configuration state, that can hold that copy low on its own.

One output of the group is exempt from the stop request. It keeps switching whenever its enable bit is set. Every copy is formed by ANDing the source clock with an enable that is registered on the falling edge. As a result, an output only starts or ends at a falling edge: it stops low, and its first high phase after a restart is always a whole one.

A restarted group stays running for a guaranteed minimum number of cycles, so a quick re-request cannot cut a burst of clocks short. In the requirements, "cycle k" is the clock period that begins at rising edge k. "Before edge k" means during the low phase that ends at edge k.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst_n` is low, every bit of `clk_out` is low. After `rst_n` rises before edge 1 with the stop request inactive, the stoppable outputs first go high in cycle 4.
- R2: An output never produces a partial pulse. It is low during every low phase of `clk_src`, and during a high phase it is either high for the whole phase or low for the whole phase.
- R3: If `stop_req_n` falls before edge k and the group has met its minimum run time, the stoppable outputs still pulse in cycles k, k+1 and k+2. They stay low from cycle k+3 onward.
- R4: If `stop_req_n` rises before edge k while the group is stopped, the first high pulse of the stoppable outputs is in cycle k+3.
- R5: Once the stoppable outputs restart, they give at least `MIN_ON` consecutive high pulses (default 10), even if the stop request returns at once. With the default settings, a restart whose first pulse is in cycle 4 runs through cycle 13.
- R6: Bit i of `en_mask` gates `clk_out[i]`. A change of the bit before edge k takes effect from the high phase of cycle k+1 onward: 0 holds the output low, and 1 lets it follow the run state.
- R7: Output `clk_out[FREE_IDX]` (bit 0 by default) ignores `stop_req_n` completely and follows only its own enable bit.
- R8: A stop pulse that covers no rising edge has no effect on any output. A stop pulse that covers exactly one rising edge removes exactly one whole high pulse, in cycle k+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock to be gated |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop request for the stoppable outputs |
| en_mask | input | N_OUT | Per-output enable, 1 lets output i switch |
| clk_out | output | N_OUT | Gated clocks; bit FREE_IDX is the free-running output |

## Verification
The hardest cases to reach from the ports are a stop request that falls entirely between two rising edges, and a re-stop issued while the minimum run window is still open.

The bench moves `stop_req_n` twice inside a single low phase to produce a pulse the synchronizer cannot see. It lowers the request again one cycle after a restart, so that only the run-time guard keeps the clocks alive.

Every cycle is probed just after the rising edge, just before the falling edge, and in the low phase. A shortened or runt pulse therefore shows up as a mismatch between probes.

// File: rtl/csg_pkg.sv
package csg_pkg;

    // Width of the run-time counter; MIN_ON must not exceed 2**CNT_W.
    parameter int unsigned CNT_W = 8;

    typedef enum logic {
        GATE_STOPPABLE = 1'b0,
        GATE_FREE      = 1'b1
    } gate_mode_e;

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } run_state_t;

endpackage

// File: rtl/csg_sync.sv
module csg_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/csg_run_ctrl.sv
module csg_run_ctrl
    import csg_pkg::*;
#(
    parameter int unsigned MIN_ON = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic run_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_ON - 1);

    run_state_t st_d;
    run_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.run) begin
            if (st_q.cnt < LAST) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            // keep running until the minimum window has elapsed
            st_d.run = go_i | (st_q.cnt < LAST);
        end else begin
            st_d.cnt = '0;
            st_d.run = go_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o = st_q.run;

    p_hold_min_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && st_q.cnt < LAST) |=> st_q.run);

    p_cnt_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

    p_stop_after_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !go_i && st_q.cnt == LAST) |=> !st_q.run);

    p_start_on_go_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && go_i) |=> st_q.run);
endmodule

// File: rtl/csg_gate_cell.sv
module csg_gate_cell
    import csg_pkg::*;
#(
    parameter gate_mode_e MODE = GATE_STOPPABLE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic mask_i,
    output logic clk_o
);
    logic en_d;
    logic en_q;

    always_comb begin
        en_d = mask_i & ((MODE == GATE_FREE) | run_i);
    end

    // Enable moves only while the clock is low, so the AND cannot chop a pulse.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_d;
        end
    end

    assign clk_o = clk & en_q;

    p_mask_holds_low_r6: assert property (@(negedge clk) disable iff (!rst_n)
        !mask_i |=> !en_q);

    if (MODE == GATE_STOPPABLE) begin : g_stop_chk
        p_stop_holds_low_r3: assert property (@(negedge clk) disable iff (!rst_n)
            !run_i |=> !en_q);
    end
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
    import csg_pkg::*;
#(
    parameter int unsigned N_OUT       = 4,
    parameter int unsigned FREE_IDX    = 0,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_ON      = 10
) (
    input  logic             clk_src,
    input  logic             rst_n,
    input  logic             stop_req_n,
    input  logic [N_OUT-1:0] en_mask,
    output logic [N_OUT-1:0] clk_out
);
    logic go_sync;
    logic run;

    csg_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b0)
    ) u_sync (
        .clk   (clk_src),
        .rst_n (rst_n),
        .din   (stop_req_n),
        .dout  (go_sync)
    );

    csg_run_ctrl #(
        .MIN_ON (MIN_ON)
    ) u_ctrl (
        .clk   (clk_src),
        .rst_n (rst_n),
        .go_i  (go_sync),
        .run_o (run)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        csg_gate_cell #(
            .MODE ((g == FREE_IDX) ? GATE_FREE : GATE_STOPPABLE)
        ) u_cell (
            .clk    (clk_src),
            .rst_n  (rst_n),
            .run_i  (run),
            .mask_i (en_mask[g]),
            .clk_o  (clk_out[g])
        );
    end
endmodule

// File: tb/test_clk_stop_gate.sv
`timescale 1ns/1ps
module test_clk_stop_gate;
    localparam int N = 4;
    localparam logic [N-1:0] GATED = 4'b1110;
    localparam logic [N-1:0] FREE  = 4'b0001;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         stop_req_n;
    logic [N-1:0] en_mask;
    logic [N-1:0] clk_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    clk_stop_gate i_clk_stop_gate (
        .clk_src    (clk),
        .rst_n      (rst_n),
        .stop_req_n (stop_req_n),
        .en_mask    (en_mask),
        .clk_out    (clk_out)
    );

    // Observe one full cycle; returns in its low phase, before the next edge.
    task automatic obs(output logic [N-1:0] e, output logic [N-1:0] l, output logic [N-1:0] o);
        @(posedge clk);
        #1 e = clk_out;
        #8 l = clk_out;
        #6 o = clk_out;
    endtask

    task automatic cyc_chk(input string tag, input int c, input logic [N-1:0] exp);
        logic [N-1:0] e, l, o;
        obs(e, l, o);
        checks++;
        if (e !== exp || l !== exp || o !== '0) begin
            errors++;
            $display("FAIL %s cycle %0d: got early=%b late=%b low=%b expected high=%b low=0000",
                     tag, c, e, l, o, exp);
        end
    endtask

    initial begin
        #(20 * 5000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [N-1:0] prev;
        rst_n = 1'b0;
        stop_req_n = 1'b1;
        en_mask = '1;
        // R1: reset holds all outputs low
        for (int i = 1; i <= 3; i++) cyc_chk("R1 reset", i, '0);
        rst_n = 1'b1;
        // R1/R4/R7: start-up, free output from cycle 2, gated from cycle 4
        for (int i = 1; i <= 14; i++)
            cyc_chk("R1 R4 R7 startup", i, ((i >= 2) ? FREE : '0) | ((i >= 4) ? GATED : '0));

        // R3: off latency, last gated pulse in cycle 3
        stop_req_n = 1'b0;
        for (int i = 1; i <= 10; i++)
            cyc_chk("R3 R7 stop", i, FREE | ((i <= 3) ? GATED : '0));

        // R5: restart and re-stop immediately, min-on window cycles 4..13
        stop_req_n = 1'b1;
        cyc_chk("R4 R5 restart", 1, FREE);
        stop_req_n = 1'b0;
        for (int i = 2; i <= 18; i++)
            cyc_chk("R5 min on", i, FREE | ((i >= 4 && i <= 13) ? GATED : '0));

        // R4: plain restart
        stop_req_n = 1'b1;
        for (int i = 1; i <= 14; i++)
            cyc_chk("R4 on latency", i, FREE | ((i >= 4) ? GATED : '0));

        // R6/R7: exhaustive mask sweep while running
        prev = '1;
        for (int m = 0; m < 16; m++) begin
            en_mask = N'(m);
            cyc_chk("R6 mask old", 1, prev);
            cyc_chk("R6 mask new", 2, N'(m));
            cyc_chk("R6 mask hold", 3, N'(m));
            prev = N'(m);
        end
        en_mask = '1;
        cyc_chk("R6 mask old", 1, prev);
        cyc_chk("R6 mask restore", 2, '1);

        // R8: request covering exactly one edge removes cycle 4 only
        stop_req_n = 1'b0;
        cyc_chk("R8 one edge", 1, '1);
        stop_req_n = 1'b1;
        for (int i = 2; i <= 14; i++)
            cyc_chk("R8 one edge", i, (i == 4) ? FREE : '1);

        // R8: request inside one low phase is never seen
        #2 stop_req_n = 1'b0;
        #2 stop_req_n = 1'b1;
        for (int i = 1; i <= 12; i++) cyc_chk("R8 R2 glitch", i, '1);

        // R7: stopped group, free output follows only its mask bit
        stop_req_n = 1'b0;
        for (int i = 1; i <= 6; i++)
            cyc_chk("R7 stopped", i, FREE | ((i <= 3) ? GATED : '0));
        prev = '1;
        for (int m = 0; m < 16; m++) begin
            en_mask = N'(m);
            cyc_chk("R7 free old", 1, prev & FREE);
            cyc_chk("R7 free new", 2, N'(m) & FREE);
            prev = N'(m);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule